// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Aligner

This block sits between the load/store stage of a 32-bit RISC core and a word-wide data memory that has per-byte write strobes. On a store request it forms the effective address and moves the store data onto the right byte lanes. It also produces the four-bit write strobe. The displacement of a store comes from two separate instruction fields, which the block joins and sign-extends. On a load request it forms the address from the ordinary 16-bit immediate and asserts a read. It keeps the low address bits, the access size and the extension mode for one cycle. When the memory returns its word in the following cycle, the block picks out the addressed lane and extends it to 32 bits.

Lanes are big-endian: byte offset 0 is the most significant byte, bits 31:24, and maps to strobe bit 3. Misaligned halfword and word accesses, and the reserved size code, are reported as faults. A faulting store drives an all-zero strobe and zero data, so memory is left unchanged. A faulting load returns zero together with a fault flag. The memory is expected to apply the strobe so that only enabled lanes change.

Top module: `lsa_lane_aligner`

## Requirements
- R1: For a store, `mem_addr` equals `base` plus the 16-bit displacement {`st_off_hi`, `st_off_lo`} sign-extended to 32 bits; `st_off_hi` supplies displacement bits 15:11.
- R2: For a load, `mem_addr` equals `base` plus `ld_imm` sign-extended to 32 bits, and `mem_rd` is high in the same cycle.
- R3: A byte store (size code 0) at offsets 0, 1, 2 and 3 places `st_data[7:0]` at bits 31:24, 23:16, 15:8 and 7:0 respectively, with strobes 4'h8, 4'h4, 4'h2 and 4'h1. The other bits are zero and it never faults.
- R4: A halfword store (size code 1) at offset 0 places `st_data[15:0]` at bits 31:16 with strobe 4'hC. At offset 2 it uses bits 15:0 with strobe 4'h3. Offsets 1 and 3 raise `st_fault` and drive strobe 0 and data 0.
- R5: A word store (size code 2) at offset 0 writes all of `st_data` with strobe 4'hF. Any nonzero offset raises `st_fault` and drives strobe 0 and data 0.
- R6: When no store is requested (`req_valid` low, or a load), `mem_wr_mask` and `mem_wr_data` are zero and `st_fault` is low.
- R7: A byte load returns, in the cycle after the request with `ld_valid` high, the lane at the registered offset under the same big-endian mapping. It is sign-extended when `req_signed` was 1 and zero-extended otherwise.
- R8: A halfword load at offset 0 returns bits 31:16 and at offset 2 returns bits 15:0, each extended per `req_signed`.
- R9: A word load at offset 0 returns the whole read word in both extension modes.
- R10: A misaligned load (halfword at an odd offset, word at a nonzero offset) raises `ld_fault` in the response cycle, and `ld_data` is zero.
- R11: Size code 3 is reserved: a store with it raises `st_fault` with strobe 0, and a load with it raises `ld_fault` with zero data.
- R12: While reset is held, and in any cycle that does not follow a load request, `ld_valid`, `ld_fault` are low and `ld_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| base | input | 32 | Base register value |
| ld_imm | input | 16 | Load displacement |
| st_off_hi | input | 5 | Store displacement bits 15:11 |
| st_off_lo | input | 11 | Store displacement bits 10:0 |
| st_data | input | 32 | Store source register |
| rd_data | input | 32 | Memory read word, valid the cycle after a load request |
| mem_addr | output | 32 | Effective byte address |
| mem_rd | output | 1 | Read request |
| mem_wr_data | output | 32 | Lane-aligned write data |
| mem_wr_mask | output | 4 | Byte write strobe, bit 3 = bits 31:24 |
| st_fault | output | 1 | Store misaligned or reserved size |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |
| ld_fault | output | 1 | Load misaligned or reserved size |

## Verification
Stores are tried at every offset for each size, so a swapped lane or strobe bit shows up as a single wrong lane. Displacements of -1, 0x0800 and 0x8000 test whether the two store fields are joined in the right order and sign-extended from bit 15. The read word has a different top bit in each byte, which sets signed results apart from zero-extended ones in each lane. Misaligned and reserved-size accesses of both kinds check that strobe and result are zeroed, and idle and load cycles check that no strobe leaks.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int OFF_HI_W = 5,
    parameter int OFF_LO_W = 11
) (
    input  logic                         is_store,
    input  logic [ADDR_W-1:0]            base,
    input  logic [OFF_HI_W+OFF_LO_W-1:0] ld_imm,
    input  logic [OFF_HI_W-1:0]          st_off_hi,
    input  logic [OFF_LO_W-1:0]          st_off_lo,
    output logic [ADDR_W-1:0]            addr
);
    localparam int IMM_W = OFF_HI_W + OFF_LO_W;

    logic [IMM_W-1:0]  disp;
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp     = is_store ? {st_off_hi, st_off_lo} : ld_imm;
        disp_ext = {{(ADDR_W-IMM_W){disp[IMM_W-1]}}, disp};
        addr     = base + disp_ext;
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e                        size,
    input  logic [$clog2(DATA_W/8)-1:0]      off,
    input  logic [DATA_W-1:0]                src,
    output logic [DATA_W-1:0]                wdata,
    output logic [DATA_W/8-1:0]              mask,
    output logic                             fault
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    always_comb begin
        wdata = '0;
        mask  = '0;
        fault = 1'b0;
        unique case (size)
            SZ_BYTE: begin
                for (int k = 0; k < LANES; k++) begin
                    if (off == OFF_W'(k)) begin
                        wdata[DATA_W-1-8*k -: 8] = src[7:0];
                        mask[LANES-1-k]          = 1'b1;
                    end
                end
            end
            SZ_HALF: begin
                fault = off[0];
                for (int k = 0; k < LANES; k += 2) begin
                    if (off == OFF_W'(k)) begin
                        wdata[DATA_W-1-8*k -: 16] = src[15:0];
                        mask[LANES-1-k -: 2]      = 2'b11;
                    end
                end
            end
            SZ_WORD: begin
                if (off != '0) begin
                    fault = 1'b1;
                end else begin
                    wdata = src;
                    mask  = '1;
                end
            end
            default: fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e                        size,
    input  logic [$clog2(DATA_W/8)-1:0]      off,
    input  logic                             sgn,
    input  logic [DATA_W-1:0]                rdata,
    output logic [DATA_W-1:0]                data,
    output logic                             fault
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = '0;
        sel_h = '0;
        for (int k = 0; k < LANES; k++) begin
            if (off == OFF_W'(k)) sel_b = rdata[DATA_W-1-8*k -: 8];
        end
        for (int k = 0; k < LANES; k += 2) begin
            if (off == OFF_W'(k)) sel_h = rdata[DATA_W-1-8*k -: 16];
        end
        data  = '0;
        fault = 1'b0;
        unique case (size)
            SZ_BYTE: data = {{(DATA_W-8){sgn & sel_b[7]}}, sel_b};
            SZ_HALF: begin
                fault = off[0];
                data  = {{(DATA_W-16){sgn & sel_h[15]}}, sel_h};
            end
            SZ_WORD: begin
                fault = (off != '0);
                data  = rdata;
            end
            default: fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_lane_aligner.sv
module lsa_lane_aligner
    import lsa_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int OFF_HI_W = 5,
    parameter int OFF_LO_W = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_store,
    input  logic [1:0]                   req_size,
    input  logic                         req_signed,
    input  logic [ADDR_W-1:0]            base,
    input  logic [OFF_HI_W+OFF_LO_W-1:0] ld_imm,
    input  logic [OFF_HI_W-1:0]          st_off_hi,
    input  logic [OFF_LO_W-1:0]          st_off_lo,
    input  logic [DATA_W-1:0]            st_data,
    input  logic [DATA_W-1:0]            rd_data,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic                         mem_rd,
    output logic [DATA_W-1:0]            mem_wr_data,
    output logic [DATA_W/8-1:0]          mem_wr_mask,
    output logic                         st_fault,
    output logic                         ld_valid,
    output logic [DATA_W-1:0]            ld_data,
    output logic                         ld_fault
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    typedef struct packed {
        logic             vld;
        logic [OFF_W-1:0] off;
        acc_size_e        size;
        logic             sgn;
    } pend_t;

    pend_t pend_d, pend_q;

    logic [DATA_W-1:0] lane_wdata;
    logic [LANES-1:0]  lane_mask;
    logic              lane_fault;
    logic [DATA_W-1:0] ext_data;
    logic              ext_fault;
    logic              is_st, is_ld;

    assign is_st = req_valid & req_store;
    assign is_ld = req_valid & ~req_store;

    lsa_addr_gen #(
        .ADDR_W(ADDR_W), .OFF_HI_W(OFF_HI_W), .OFF_LO_W(OFF_LO_W)
    ) u_addr (
        .is_store(req_store), .base(base), .ld_imm(ld_imm),
        .st_off_hi(st_off_hi), .st_off_lo(st_off_lo), .addr(mem_addr)
    );

    lsa_store_lanes #(.DATA_W(DATA_W)) u_st (
        .size(acc_size_e'(req_size)), .off(mem_addr[OFF_W-1:0]), .src(st_data),
        .wdata(lane_wdata), .mask(lane_mask), .fault(lane_fault)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_ld (
        .size(pend_q.size), .off(pend_q.off), .sgn(pend_q.sgn), .rdata(rd_data),
        .data(ext_data), .fault(ext_fault)
    );

    always_comb begin
        pend_d = '0;
        if (is_ld) begin
            pend_d.vld  = 1'b1;
            pend_d.off  = mem_addr[OFF_W-1:0];
            pend_d.size = acc_size_e'(req_size);
            pend_d.sgn  = req_signed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    always_comb begin
        mem_rd      = is_ld;
        st_fault    = is_st & lane_fault;
        mem_wr_mask = (is_st && !lane_fault) ? lane_mask  : '0;
        mem_wr_data = (is_st && !lane_fault) ? lane_wdata : '0;
        ld_valid    = pend_q.vld;
        ld_fault    = pend_q.vld & ext_fault;
        ld_data     = (pend_q.vld && !ext_fault) ? ext_data : '0;
    end

    // R3
    byte_store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_st && req_size == 2'd0) |-> ($countones(mem_wr_mask) == 1 && !st_fault));
    // R4
    half_store_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_st && req_size == 2'd1 && !st_fault) |-> ($countones(mem_wr_mask) == 2));
    // R5
    faulted_store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |-> (mem_wr_mask == '0 && mem_wr_data == '0));
    // R11
    rsvd_store_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_st && req_size == 2'd3) |-> st_fault);
    // R7
    load_response_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ld |=> ld_valid);
    // R12
    no_spurious_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ld |=> (!ld_valid && !ld_fault));
    // R10
    faulted_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault |-> (ld_data == '0 && ld_valid));
endmodule

// File: tb/tb_lsa_lane_aligner.sv
module tb_lsa_lane_aligner;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_signed;
    logic [1:0]  req_size;
    logic [31:0] base, st_data, rd_data;
    logic [15:0] ld_imm;
    logic [4:0]  st_off_hi;
    logic [10:0] st_off_lo;
    logic [31:0] mem_addr, mem_wr_data, ld_data;
    logic        mem_rd, st_fault, ld_valid, ld_fault;
    logic [3:0]  mem_wr_mask;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsa_lane_aligner dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .base(base), .ld_imm(ld_imm),
        .st_off_hi(st_off_hi), .st_off_lo(st_off_lo), .st_data(st_data),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask), .st_fault(st_fault),
        .ld_valid(ld_valid), .ld_data(ld_data), .ld_fault(ld_fault)
    );

    typedef struct packed {
        logic [1:0]  sz;
        logic [31:0] b;
        logic [4:0]  hi;
        logic [10:0] lo;
        logic [31:0] ea;
        logic [31:0] ed;
        logic [3:0]  em;
        logic        ef;
    } svec_t;

    localparam int NSV = 14;
    localparam svec_t SV [NSV] = '{
        '{2'd0, 32'h10000000, 5'h00, 11'h000, 32'h10000000, 32'hD4000000, 4'h8, 1'b0},
        '{2'd0, 32'h10000000, 5'h00, 11'h001, 32'h10000001, 32'h00D40000, 4'h4, 1'b0},
        '{2'd0, 32'h10000002, 5'h00, 11'h000, 32'h10000002, 32'h0000D400, 4'h2, 1'b0},
        '{2'd0, 32'h10000000, 5'h00, 11'h003, 32'h10000003, 32'h000000D4, 4'h1, 1'b0},
        '{2'd1, 32'h20000000, 5'h00, 11'h000, 32'h20000000, 32'hC3D40000, 4'hC, 1'b0},
        '{2'd1, 32'h20000000, 5'h00, 11'h002, 32'h20000002, 32'h0000C3D4, 4'h3, 1'b0},
        '{2'd1, 32'h20000000, 5'h00, 11'h001, 32'h20000001, 32'h00000000, 4'h0, 1'b1},
        '{2'd1, 32'h20000000, 5'h00, 11'h003, 32'h20000003, 32'h00000000, 4'h0, 1'b1},
        '{2'd2, 32'h30000000, 5'h00, 11'h000, 32'h30000000, 32'hA1B2C3D4, 4'hF, 1'b0},
        '{2'd2, 32'h30000000, 5'h00, 11'h002, 32'h30000002, 32'h00000000, 4'h0, 1'b1},
        '{2'd3, 32'h30000000, 5'h00, 11'h000, 32'h30000000, 32'h00000000, 4'h0, 1'b1},
        '{2'd0, 32'h00001000, 5'h1F, 11'h7FF, 32'h00000FFF, 32'h000000D4, 4'h1, 1'b0},
        '{2'd2, 32'h40000000, 5'h01, 11'h000, 32'h40000800, 32'hA1B2C3D4, 4'hF, 1'b0},
        '{2'd1, 32'h00010000, 5'h10, 11'h000, 32'h00008000, 32'hC3D40000, 4'hC, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0; req_signed = 1'b0;
        base = '0; ld_imm = '0; st_off_hi = '0; st_off_lo = '0;
    endtask

    task automatic do_load(input logic [31:0] b, input logic [15:0] imm,
                           input logic [1:0] sz, input logic sg,
                           input logic [31:0] exp_addr, input logic [31:0] exp_data,
                           input logic exp_fault, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_size = sz; req_signed = sg;
        base = b; ld_imm = imm; st_off_hi = 5'h1F; st_off_lo = 11'h000;
        #1;
        chk("R2 load address", mem_addr, exp_addr);
        chk("R2 mem_rd", {31'd0, mem_rd}, 32'd1);
        chk("R6 no strobe on load", {28'd0, mem_wr_mask}, 32'd0);
        @(negedge clk);
        idle();
        rd_data = 32'h8142F314;
        #1;
        chk({req, " ld_valid"}, {31'd0, ld_valid}, 32'd1);
        chk({req, " ld_data"}, ld_data, exp_data);
        chk({req, " ld_fault"}, {31'd0, ld_fault}, {31'd0, exp_fault});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle();
        st_data = 32'hA1B2C3D4;
        rd_data = 32'h8142F314;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R12 reset ld_data", ld_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // store vectors: R1 R3 R4 R5 R11
        for (int i = 0; i < NSV; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_store = 1'b1; req_size = SV[i].sz;
            base = SV[i].b; st_off_hi = SV[i].hi; st_off_lo = SV[i].lo;
            ld_imm = 16'h7777;
            #1;
            chk("R1 store address", mem_addr, SV[i].ea);
            chk("R3/R4/R5 store data", mem_wr_data, SV[i].ed);
            chk("R3/R4/R5 store mask", {28'd0, mem_wr_mask}, {28'd0, SV[i].em});
            chk("R11 store fault", {31'd0, st_fault}, {31'd0, SV[i].ef});
            chk("R6 no read on store", {31'd0, mem_rd}, 32'd0);
            @(negedge clk);
            idle();
            #1;
            chk("R12 no response after store", {31'd0, ld_valid}, 32'd0);
        end

        // R6 store fields present but req_valid low
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b1; req_size = 2'd2;
        #1;
        chk("R6 idle mask", {28'd0, mem_wr_mask}, 32'd0);
        chk("R6 idle data", mem_wr_data, 32'd0);
        chk("R6 idle fault", {31'd0, st_fault}, 32'd0);
        idle();

        // loads, read word 8142F314
        do_load(32'h50000000, 16'h0000, 2'd0, 1'b1, 32'h50000000, 32'hFFFFFF81, 1'b0, "R7 byte0 signed");
        do_load(32'h50000000, 16'h0000, 2'd0, 1'b0, 32'h50000000, 32'h00000081, 1'b0, "R7 byte0 zero");
        do_load(32'h50000000, 16'h0001, 2'd0, 1'b1, 32'h50000001, 32'h00000042, 1'b0, "R7 byte1 signed");
        do_load(32'h50000004, 16'hFFFE, 2'd0, 1'b1, 32'h50000002, 32'hFFFFFFF3, 1'b0, "R7 byte2 signed");
        do_load(32'h50000000, 16'h0003, 2'd0, 1'b0, 32'h50000003, 32'h00000014, 1'b0, "R7 byte3 zero");
        do_load(32'h50000000, 16'h0000, 2'd1, 1'b1, 32'h50000000, 32'hFFFF8142, 1'b0, "R8 half0 signed");
        do_load(32'h50000000, 16'h0000, 2'd1, 1'b0, 32'h50000000, 32'h00008142, 1'b0, "R8 half0 zero");
        do_load(32'h50000000, 16'h0002, 2'd1, 1'b1, 32'h50000002, 32'hFFFFF314, 1'b0, "R8 half2 signed");
        do_load(32'h50000000, 16'h0002, 2'd1, 1'b0, 32'h50000002, 32'h0000F314, 1'b0, "R8 half2 zero");
        do_load(32'h50000000, 16'h0000, 2'd2, 1'b1, 32'h50000000, 32'h8142F314, 1'b0, "R9 word signed");
        do_load(32'h50000000, 16'h0000, 2'd2, 1'b0, 32'h50000000, 32'h8142F314, 1'b0, "R9 word zero");
        do_load(32'h50000000, 16'h0001, 2'd1, 1'b1, 32'h50000001, 32'h00000000, 1'b1, "R10 half misaligned");
        do_load(32'h50000000, 16'h0002, 2'd2, 1'b0, 32'h50000002, 32'h00000000, 1'b1, "R10 word misaligned");
        do_load(32'h50000000, 16'h0000, 2'd3, 1'b0, 32'h50000000, 32'h00000000, 1'b1, "R11 reserved load");

        @(negedge clk);
        #1;
        chk("R12 idle ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R12 idle ld_fault", {31'd0, ld_fault}, 32'd0);
        chk("R12 idle ld_data", ld_data, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule